// File: doc/BRIEF.md
# Serial flash command sequencer

This block is a SPI master dedicated to serial flash parts, driven by software through a small register window. Software loads an address register and a 32-bit data register, then writes one command word. That write starts one access on the wire. The access is an opcode byte, then up to three address bytes, then up to fifteen dummy bytes, then up to four data bytes that are either sent or captured. The wire runs in SPI mode 0: SCK idles low, MOSI changes while SCK is low, and MISO is sampled on the rising edge. Bytes go out most significant bit first.

Chip select can be held asserted after an access ends. This lets software chain several commands into one long flash transaction. A command issued while chip select is still held skips the opcode byte and goes straight on with its address, dummy and data phases. A command with no phases left and keep-selected clear only releases chip select.

Bit pacing comes from an external timing strobe. Each strobe advances SCK by one half period. Two register bits drive the flash HOLD and WP lines. A size field masks the address that goes onto the wire.

Top module: `sflash_seq`

## Requirements
- R1: A write to the command register (word offset 0) while no access is pending starts an access. Status bit 22 (offset 3) reads 1 from the next cycle until the cycle after the last SCK falling edge.
- R2: Command word fields are: opcode 7:0, write direction 8, data count 11:9 (values above 4 act as 4), keep-selected 15, dummy count 19:16, address count 22:20 (values above 3 act as 3), chip-select index 26:24. The wire order is opcode, address, dummy, then data. Each bit takes one strobe with SCK low, then one strobe with SCK high.
- R3: In a write access, data bytes come from the data register (offset 2) little-endian. Bits 7:0 go out first and bits 31:24 go out fourth.
- R4: In a read access, MISO is sampled on each rising SCK edge. The first byte received lands in bits 7:0 of the data register and the fourth in bits 31:24. Bytes beyond the count keep their old value.
- R5: Chip select (active low, selected by the command's index) asserts in the cycle after the command write. It is released at the end of the access when keep-selected is clear, and stays asserted when keep-selected is set.
- R6: A command issued while chip select is still held sends no opcode. A command with no address, dummy or data bytes and keep-selected clear only releases chip select.
- R7: A command write while an access is pending is ignored and sets status bit 29. Writing 1 to status bit 29 clears it.
- R8: MOSI is low during dummy bytes, during read data bytes and when idle.
- R9: Bit 3 of the I/O control register (offset 4) drives hold_n and bit 2 drives wp_n. Both reset to 0.
- R10: The size field, bits 27:24 of the configuration register (offset 5), resets to 3. The value 1 keeps address bits 7:0 on the wire, 2 keeps bits 15:0, and any other value keeps all 24 bits. Bits that are not kept go out as 0.
- R11: After reset, every chip select is high, SCK and MOSI are low, and the status register reads 0.
- R12: Writes to the address register (offset 1, 24 bits) and to the data register are ignored while an access is pending.
- R13: The command register reads back the last accepted command word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Half-period strobe from the timing generator |
| bus_we | input | 1 | Register write enable |
| bus_addr | input | AW | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| cs_n | output | NCS | Chip selects, active low |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to flash |
| miso | input | 1 | Serial data from flash |
| hold_n | output | 1 | Flash HOLD line |
| wp_n | output | 1 | Flash WP line |

## Verification
The bench runs several kinds of access:
- An opcode-only command checks the shortest frame.
- Full write and read commands with three address bytes check byte order and the little-endian packing of the data register.
- A read with fifteen dummy bytes checks the longest dummy phase.
- A three-command chain on a non-zero chip select separates opcode skipping and held select from the release-only command.
- Oversized field values check the clamping of the counts.
- Different address sizes check the wire masking.
- Command, address and data writes during a pending access check that the rejected writes change nothing.

The timing strobe runs every cycle, every third cycle and at random. This confirms that SCK moves only on a strobe.

// File: rtl/sflash_seq.sv
`timescale 1ns/1ps
module sflash_seq #(
  parameter int NCS = 8,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCS-1:0] cs_n,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic           hold_n,
  output logic           wp_n
);
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1;
  localparam logic [AW-1:0] A_CMD = AW'(0), A_ADR = AW'(1), A_DAT = AW'(2),
                            A_STA = AW'(3), A_IO = AW'(4), A_CFG = AW'(5);

  typedef enum logic [2:0] {PH_OP, PH_ADR, PH_DUM, PH_DAT, PH_END} ph_t;

  logic [31:0]    cmd_q, data_q;
  logic [23:0]    addr_q;
  logic [3:0]     size_q, bcnt;
  logic [1:0]     io_q;
  logic [2:0]     bitc;
  logic [7:0]     rx_sh;
  logic [CSW-1:0] sel;
  logic           err_q, busy, held, sck_q;
  ph_t            ph;

  function automatic logic [1:0] cl_a(logic [2:0] v);
    return (v > 3'd3) ? 2'd3 : v[1:0];
  endfunction
  function automatic logic [2:0] cl_d(logic [2:0] v);
    return (v > 3'd4) ? 3'd4 : v;
  endfunction
  function automatic ph_t first_from(ph_t p, logic [1:0] a, logic [3:0] d, logic [2:0] n);
    ph_t r = PH_END;
    if (p <= PH_DAT && n != 0) r = PH_DAT;
    if (p <= PH_DUM && d != 0) r = PH_DUM;
    if (p <= PH_ADR && a != 0) r = PH_ADR;
    if (p == PH_OP) r = PH_OP;
    return r;
  endfunction

  wire [1:0] alen = cl_a(cmd_q[22:20]);
  wire [3:0] dum  = cmd_q[19:16];
  wire [2:0] dlen = cl_d(cmd_q[11:9]);
  wire       dir  = cmd_q[8];
  wire       keep = cmd_q[15];

  wire start  = bus_we && bus_addr == A_CMD && !busy;
  wire cmd_rj = bus_we && bus_addr == A_CMD && busy;

  logic [3:0] ph_cnt;
  always_comb
    case (ph)
      PH_OP:   ph_cnt = 4'd1;
      PH_ADR:  ph_cnt = {2'b0, alen};
      PH_DUM:  ph_cnt = dum;
      PH_DAT:  ph_cnt = {1'b0, dlen};
      default: ph_cnt = 4'd0;
    endcase

  logic [23:0] amask;
  always_comb
    case (size_q)
      4'd1:    amask = 24'h0000FF;
      4'd2:    amask = 24'h00FFFF;
      default: amask = 24'hFFFFFF;
    endcase

  wire [31:0] am    = {8'd0, addr_q & amask};
  wire [1:0]  ai    = 2'(alen - 2'd1 - bcnt[1:0]);
  wire [7:0]  adr_b = am[{ai, 3'b000} +: 8];
  wire [7:0]  dat_b = data_q[{bcnt[1:0], 3'b000} +: 8];

  logic [7:0] tx_byte;
  always_comb
    case (ph)
      PH_OP:   tx_byte = cmd_q[7:0];
      PH_ADR:  tx_byte = adr_b;
      PH_DAT:  tx_byte = dir ? dat_b : 8'd0;
      default: tx_byte = 8'd0;
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cmd_q <= '0; data_q <= '0; addr_q <= '0; busy <= 1'b0; held <= 1'b0;
      sel <= '0; ph <= PH_END; bcnt <= '0; bitc <= '0; sck_q <= 1'b0; rx_sh <= '0;
    end else if (start) begin
      cmd_q <= bus_wdata;
      busy  <= 1'b1;
      held  <= 1'b1;
      sel   <= bus_wdata[24 +: CSW];
      ph    <= first_from(held ? PH_ADR : PH_OP, cl_a(bus_wdata[22:20]),
                          bus_wdata[19:16], cl_d(bus_wdata[11:9]));
      bcnt  <= '0;
      bitc  <= '0;
      sck_q <= 1'b0;
    end else if (busy) begin
      if (ph == PH_END) begin
        busy <= 1'b0;
        if (!keep) held <= 1'b0;
      end else if (tick) begin
        if (!sck_q) begin
          sck_q <= 1'b1;
          rx_sh <= {rx_sh[6:0], miso};
        end else begin
          sck_q <= 1'b0;
          bitc  <= bitc + 3'd1;
          if (bitc == 3'd7) begin
            if (ph == PH_DAT && !dir) data_q[{bcnt[1:0], 3'b000} +: 8] <= rx_sh;
            if (bcnt + 4'd1 == ph_cnt) begin
              bcnt <= '0;
              ph   <= first_from(ph_t'(3'(ph) + 3'd1), alen, dum, dlen);
            end else bcnt <= bcnt + 4'd1;
          end
        end
      end
    end else if (bus_we && bus_addr == A_DAT) data_q <= bus_wdata;
    else if (bus_we && bus_addr == A_ADR) addr_q <= bus_wdata[23:0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_q <= 1'b0; io_q <= 2'b00; size_q <= 4'd3;
    end else begin
      if (cmd_rj) err_q <= 1'b1;
      else if (bus_we && bus_addr == A_STA && bus_wdata[29]) err_q <= 1'b0;
      if (bus_we && bus_addr == A_IO)  io_q   <= bus_wdata[3:2];
      if (bus_we && bus_addr == A_CFG) size_q <= bus_wdata[27:24];
    end

  for (genvar g = 0; g < NCS; g++) begin : g_cs
    assign cs_n[g] = !(held && sel == CSW'(g));
  end

  assign sck    = sck_q;
  assign mosi   = busy && tx_byte[3'd7 - bitc];
  assign hold_n = io_q[1];
  assign wp_n   = io_q[0];

  always_comb
    case (bus_addr)
      A_CMD:   bus_rdata = cmd_q;
      A_ADR:   bus_rdata = {8'd0, addr_q};
      A_DAT:   bus_rdata = data_q;
      A_STA:   bus_rdata = {2'b00, err_q, 6'd0, busy, 22'd0};
      A_IO:    bus_rdata = {28'd0, io_q, 2'b00};
      A_CFG:   bus_rdata = {4'd0, size_q, 24'd0};
      default: bus_rdata = 32'd0;
    endcase

  p_pend_held_r1: assert property (@(posedge clk) disable iff (!rst_n) busy |-> held);
  p_idle_sck_r8: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sck_q);
  p_sck_tick_r2: assert property (@(posedge clk) disable iff (!rst_n) !$past(tick) |-> $stable(sck_q));
  p_reject_err_r7: assert property (@(posedge clk) disable iff (!rst_n) cmd_rj |=> err_q);
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n) ($fell(busy) && !keep) |-> &cs_n);
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n) ($fell(busy) && keep) |-> !(&cs_n));
  p_cs_one_r5: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~cs_n));
endmodule

// File: tb/tb_sflash_seq.sv
`timescale 1ns/1ps
module tb_sflash_seq;
  localparam int CLK_P = 10;
  localparam int NCS = 8;

  logic clk = 0, rst_n = 0, tick = 0, bus_we = 0, miso = 0;
  logic [2:0] bus_addr = 3'd3;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NCS-1:0] cs_n;
  logic sck, mosi, hold_n, wp_n;

  sflash_seq #(.NCS(NCS), .AW(3)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cs_n(cs_n), .sck(sck),
    .mosi(mosi), .miso(miso), .hold_n(hold_n), .wp_n(wp_n));

  always #(CLK_P/2) clk = ~clk;

  int checks = 0, errors = 0, tick_div = 1, tcnt = 0;
  bit done = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    miso <= lfsr[3];
    tcnt <= tcnt + 1;
    tick <= (tick_div == 0) ? lfsr[7] : ((tcnt % tick_div) == 0);
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  bit m_busy, m_held, m_sck, m_err, m_keep;
  int m_sel;
  logic [31:0] m_cmd, m_data, m_tmp;
  logic [23:0] m_addr;
  logic [1:0] m_io;
  logic [3:0] m_size;
  int q_bit[$], q_cap[$];

  function automatic logic [31:0] exp_rd(logic [2:0] a);
    case (a)
      3'd0: return m_cmd;
      3'd1: return {8'd0, m_addr};
      3'd2: return m_data;
      3'd3: return (32'(m_err) << 29) | (32'(m_busy) << 22);
      3'd4: return {28'd0, m_io, 2'b00};
      3'd5: return {4'd0, m_size, 24'd0};
      default: return 32'd0;
    endcase
  endfunction

  task automatic push_byte(logic [7:0] b, int cap_base);
    for (int i = 7; i >= 0; i--) begin
      q_bit.push_back(int'(b[i]));
      q_cap.push_back(cap_base < 0 ? -1 : cap_base + i);
    end
  endtask

  task automatic m_start(logic [31:0] w);
    int al, dm, dl;
    logic [23:0] ma;
    al = (w[22:20] > 3) ? 3 : int'(w[22:20]);
    dl = (w[11:9] > 4) ? 4 : int'(w[11:9]);
    dm = int'(w[19:16]);
    ma = (m_size == 1) ? (m_addr & 24'hFF) : (m_size == 2) ? (m_addr & 24'hFFFF) : m_addr;
    m_cmd = w; m_busy = 1; m_keep = w[15]; m_sel = int'(w[26:24]); m_sck = 0;
    if (!m_held) push_byte(w[7:0], -1);
    m_held = 1;
    for (int i = 0; i < al; i++) push_byte(8'(ma >> (8 * (al - 1 - i))), -1);
    for (int i = 0; i < dm; i++) push_byte(8'd0, -1);
    for (int k = 0; k < dl; k++)
      if (w[8]) push_byte(m_data[8*k +: 8], -1);
      else push_byte(8'd0, 8 * k);
  endtask

  always @(posedge clk) begin
    bit wb;
    if (!rst_n) begin
      m_busy = 0; m_held = 0; m_sck = 0; m_err = 0; m_keep = 0; m_sel = 0;
      m_cmd = 0; m_data = 0; m_tmp = 0; m_addr = 0; m_io = 0; m_size = 3;
      q_bit.delete(); q_cap.delete();
    end else begin
      wb = m_busy;
      if (bus_we)
        case (bus_addr)
          3'd0: if (wb) m_err = 1; else m_start(bus_wdata);
          3'd1: if (!wb) m_addr = bus_wdata[23:0];
          3'd2: if (!wb) m_data = bus_wdata;
          3'd3: if (bus_wdata[29]) m_err = 0;
          3'd4: m_io = bus_wdata[3:2];
          3'd5: m_size = bus_wdata[27:24];
          default: ;
        endcase
      if (wb) begin
        if (q_bit.size() == 0) begin
          m_busy = 0;
          if (!m_keep) m_held = 0;
        end else if (tick) begin
          if (!m_sck) begin
            m_sck = 1;
            if (q_cap[0] >= 0) m_tmp[q_cap[0]] = miso;
          end else begin
            m_sck = 0;
            if (q_cap[0] >= 0 && q_cap[0] % 8 == 0) m_data[q_cap[0] +: 8] = m_tmp[q_cap[0] +: 8];
            void'(q_bit.pop_front());
            void'(q_cap.pop_front());
          end
        end
      end
    end
    #1;
    if (!done) begin
      logic [NCS-1:0] ecs;
      ecs = '1;
      if (m_held) ecs[m_sel] = 1'b0;
      chk("R5 R6 cs_n", 32'(cs_n), 32'(ecs));
      chk("R2 sck", 32'(sck), 32'(m_sck));
      chk("R2 R3 R8 mosi", 32'(mosi), (m_busy && q_bit.size() > 0) ? 32'(q_bit[0]) : 32'd0);
      chk("R9 hold_n/wp_n", {30'd0, hold_n, wp_n}, {30'd0, m_io});
      case (bus_addr)
        3'd0: chk("R13 command readback", bus_rdata, exp_rd(bus_addr));
        3'd1: chk("R12 address register", bus_rdata, exp_rd(bus_addr));
        3'd2: chk("R4 R12 data register", bus_rdata, exp_rd(bus_addr));
        3'd3: chk("R1 R7 status", bus_rdata, exp_rd(bus_addr));
        3'd4: chk("R9 io register", bus_rdata, exp_rd(bus_addr));
        default: chk("R10 config", bus_rdata, exp_rd(bus_addr));
      endcase
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = 3'd3;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (!m_busy) break;
    end
  endtask

  task automatic run(logic [31:0] w);
    wr(3'd0, w);
    wait_idle();
  endtask

  task automatic peek(logic [2:0] a);
    @(negedge clk); bus_addr = a;
    @(negedge clk); bus_addr = 3'd3;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11 reset cs_n", 32'(cs_n), 32'hFF);
    chk("R11 reset sck", 32'(sck), 0);
    chk("R11 reset mosi", 32'(mosi), 0);
    chk("R11 reset status", bus_rdata, 0);
    peek(3'd5);
    wr(3'd4, 32'hC);
    wr(3'd4, 32'h4);
    wr(3'd4, 32'hC);
    wr(3'd1, 32'h00A1B2C3);
    wr(3'd2, 32'h44332211);
    peek(3'd1); peek(3'd2);
    run(32'h0000_0006);
    run(32'h02 | (1 << 8) | (4 << 9) | (3 << 20));
    tick_div = 3;
    run(32'h0B | (4 << 9) | (1 << 16) | (3 << 20));
    peek(3'd2); peek(3'd0);
    tick_div = 0;
    run(32'h03 | (3 << 20) | (4 << 9) | (1 << 15) | (5 << 24));
    peek(3'd2);
    run((2 << 9) | (1 << 15) | (5 << 24));
    peek(3'd2);
    run(5 << 24);
    tick_div = 2;
    wr(3'd0, 32'h0B | (3 << 20) | (4 << 9));
    repeat (5) @(negedge clk);
    wr(3'd0, 32'h9F);
    wr(3'd1, 32'h00123456);
    wr(3'd2, 32'hDEADBEEF);
    wait_idle();
    peek(3'd1); peek(3'd2); peek(3'd0);
    wr(3'd3, 32'h2000_0000);
    peek(3'd3);
    tick_div = 1;
    wr(3'd5, 32'h0100_0000);
    run(32'h02 | (1 << 8) | (1 << 9) | (3 << 20));
    wr(3'd5, 32'h0200_0000);
    run(32'h02 | (1 << 8) | (2 << 9) | (2 << 20));
    wr(3'd5, 32'h0300_0000);
    peek(3'd5);
    run(32'h0B | (15 << 16) | (1 << 9) | (1 << 20));
    peek(3'd2);
    wr(3'd2, 32'h8877_6655);
    run(32'hA5 | (1 << 8) | (7 << 9) | (7 << 20) | (2 << 24));
    run(32'h5A | (7 << 9) | (1 << 15) | (7 << 24));
    run(7 << 24);
    peek(3'd2);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule